// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Output Writes

This block is a memory-mapped general-purpose I/O controller for four banks of pins (32, 22, 32 and 32 pins, 118 in all). Each bank keeps an output value, a direction setting and an output-enable setting, and it exposes the sampled pin levels for reading. The pad side is three flat vectors: output level, output enable and input level. Bank 0 owns the lowest bits of each vector and the other banks follow in bank order.

Software changes output levels through two write-only masked-data registers per bank, one for each 16-pin half. The upper half of the written word is a per-bit keep mask, where a 1 preserves the bit. The lower half holds the new levels. One bus write can therefore set or clear any chosen pins without a read-modify-write sequence. Two pins of bank 0 are tied to output direction and cannot be turned into inputs.

Direction and enable registers can be read back. The input register returns pad levels after a two-stage synchroniser. The bus is a plain address / write strobe / write data port with combinational read data.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every output level bit and every output-enable bit is 0 and `pad_oe` is all zero. Every direction bit is 0 except bank 0 pins 7 and 8, which read 1.
- R2: Pads pack into the flat vectors bank by bank. Bank 0 starts at bit 0, bank 1 (22 pins) at bit 32, bank 2 at bit 54 and bank 3 at bit 86.
- R3: A write to byte address 8*b updates bank b pins 0..15. Bits [31:16] are a keep mask. For each pin i, a mask bit of 0 loads data bit i and a mask bit of 1 leaves the pin unchanged. A mask of all ones changes nothing.
- R4: A write to byte address 8*b+4 does the same for bank b pins 16..31. Mask bit 16+j and data bit j govern pin 16+j.
- R5: A masked-data write changes `pad_out` at the first rising clock edge on which `bus_we` is high for that address.
- R6: A read at 0x60+4*b returns bank b's pad input levels, with pin i in bit i. A level change is visible two rising edges after it is applied.
- R7: The direction register of bank b sits at 0x204+0x40*b and can be read and written. A bit value of 1 means output.
- R8: The output-enable register of bank b sits at 0x208+0x40*b and can be read and written. A pad is driven (`pad_oe`=1) only when both its direction bit and its enable bit are 1.
- R9: The direction bits of bank 0 pins 7 and 8 always read 1. Writes that try to clear them have no effect.
- R10: Bits at or above a bank's pin count read as 0 in every register and ignore writes. For bank 1 these are bits 31..22.
- R11: Reads of the masked-data addresses (0x00..0x1C) and of unmapped addresses return 0. Writes to the input registers or to unmapped addresses change no state.
- R12: While `bus_we` is low, `pad_out` and `pad_oe` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 118 | Pad input levels, asynchronous |
| pad_out | output | 118 | Pad output levels |
| pad_oe | output | 118 | Pad output enables |

## Verification
Three result timings are in play. Register writes, including masked-data writes, show on `pad_out` and `pad_oe` right after the first rising edge of the strobe cycle. Read data follows the address within the same cycle. Pad input levels reach the input register only after two edges. The scoreboard queues each expectation at the falling edge where the stimulus is applied. The monitor compares shortly after the next rising edge, so a write that lands one cycle late fails. The synchroniser test queues the old value for the first edge and the new value for the second.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int ADDR_W = 12,
  parameter int W0 = 32,
  parameter int W1 = 22,
  parameter int W2 = 32,
  parameter int W3 = 32,
  localparam int NPIN = W0 + W1 + W2 + W3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe
);

  localparam int NB = 4;
  localparam logic [31:0] PINNED = 32'h0000_0180;

  function automatic int bank_w(input int b);
    case (b)
      0:       return W0;
      1:       return W1;
      2:       return W2;
      default: return W3;
    endcase
  endfunction

  function automatic int bank_lo(input int b);
    int s;
    s = 0;
    for (int k = 0; k < b; k++) s += bank_w(k);
    return s;
  endfunction

  function automatic logic [31:0] bank_mask(input int b);
    return (bank_w(b) >= 32) ? 32'hFFFF_FFFF : ((32'd1 << bank_w(b)) - 32'd1);
  endfunction

  logic [NPIN-1:0] meta_q, sync_q;
  logic [31:0] rd_in  [NB];
  logic [31:0] rd_dir [NB];
  logic [31:0] rd_oen [NB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int LO  = bank_lo(b);
    localparam int WID = bank_w(b);
    localparam logic [31:0] VALID = bank_mask(b);
    localparam logic [31:0] FIXED = (b == 0) ? PINNED : 32'h0;

    logic [31:0] out_q, dir_q, oen_q;
    logic [15:0] keep;
    logic wr_lo, wr_hi, wr_dir, wr_oen;

    assign keep   = bus_wdata[31:16];
    assign wr_lo  = bus_we && (bus_addr == ADDR_W'(8 * b));
    assign wr_hi  = bus_we && (bus_addr == ADDR_W'(8 * b + 4));
    assign wr_dir = bus_we && (bus_addr == ADDR_W'(32'h204 + 32'h40 * b));
    assign wr_oen = bus_we && (bus_addr == ADDR_W'(32'h208 + 32'h40 * b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q <= '0;
        dir_q <= FIXED;
        oen_q <= '0;
      end else begin
        if (wr_lo)
          out_q[15:0] <= ((out_q[15:0] & keep) | (bus_wdata[15:0] & ~keep)) & VALID[15:0];
        if (wr_hi)
          out_q[31:16] <= ((out_q[31:16] & keep) | (bus_wdata[15:0] & ~keep)) & VALID[31:16];
        if (wr_dir)
          dir_q <= (bus_wdata & VALID) | FIXED;
        if (wr_oen)
          oen_q <= bus_wdata & VALID;
      end
    end

    assign pad_out[LO +: WID] = out_q[WID-1:0];
    assign pad_oe[LO +: WID]  = dir_q[WID-1:0] & oen_q[WID-1:0];
    assign rd_in[b]  = 32'(sync_q[LO +: WID]);
    assign rd_dir[b] = dir_q;
    assign rd_oen[b] = oen_q;

    // R3
    full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && (&keep)) |=> $stable(out_q));

    if (b == 0) begin : g_pinned
      // R9
      pinned_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q & PINNED) == PINNED);
    end

    if (WID < 32) begin : g_narrow
      // R10
      upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q[31:WID] == '0) && (dir_q[31:WID] == '0) && (oen_q[31:WID] == '0));
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NB; b++) begin
      if (bus_addr == ADDR_W'(32'h60 + 4 * b))           bus_rdata = rd_in[b];
      if (bus_addr == ADDR_W'(32'h204 + 32'h40 * b))     bus_rdata = rd_dir[b];
      if (bus_addr == ADDR_W'(32'h208 + 32'h40 * b))     bus_rdata = rd_oen[b];
    end
  end

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(pad_out) && $stable(pad_oe)));

  // R11
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr < ADDR_W'(8 * NB)) |-> (bus_rdata == '0));

endmodule

// File: tb/gpio_bank_ctrl_test.sv
module gpio_bank_ctrl_test;
  localparam int NPIN = 118;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NPIN-1:0] pad_in = '0;
  logic [NPIN-1:0] pad_out, pad_oe;

  always #5 clk = ~clk;

  gpio_bank_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  typedef struct {
    int kind;
    logic [NPIN-1:0] exp;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [NPIN-1:0] m_out = '0;
  logic [NPIN-1:0] m_oe = '0;
  logic [31:0] m_dir [4] = '{32'h180, 32'h0, 32'h0, 32'h0};
  logic [31:0] m_oen [4] = '{32'h0, 32'h0, 32'h0, 32'h0};

  function automatic int blo(input int b);
    case (b) 0: return 0; 1: return 32; 2: return 54; default: return 86; endcase
  endfunction
  function automatic int bwid(input int b);
    return (b == 1) ? 22 : 32;
  endfunction

  task automatic put_bank(ref logic [NPIN-1:0] v, input int b, input logic [31:0] val);
    for (int i = 0; i < bwid(b); i++) v[blo(b) + i] = val[i];
  endtask

  task automatic refresh_oe();
    for (int b = 0; b < 4; b++) put_bank(m_oe, b, m_dir[b] & m_oen[b]);
  endtask

  task automatic push(input int kind, input logic [NPIN-1:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [NPIN-1:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = NPIN'(bus_rdata);
          1: act = pad_out;
          default: act = pad_oe;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    refresh_oe();
    push(1, m_out, tag);
    push(2, m_oe, tag);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    push(0, NPIN'(exp), tag);
  endtask

  task automatic pads(input string tag);
    @(negedge clk);
    refresh_oe();
    push(1, m_out, tag);
    push(2, m_oe, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    pads("R1 reset pads");
    rd(12'h204, 32'h0000_0180, "R1 R9 bank0 dir reset");
    rd(12'h208, 32'h0, "R1 bank0 oen reset");
    rd(12'h244, 32'h0, "R1 bank1 dir reset");

    // R3 R5 full low-half write, visible after first edge
    put_bank(m_out, 0, 32'h0000_A5A5);
    wr(12'h000, 32'h0000_A5A5, "R3 R5 low half load");
    // R3 partial mask
    put_bank(m_out, 0, 32'h0000_A534);
    wr(12'h000, 32'hFF00_1234, "R3 partial keep mask");
    // R4 high half
    put_bank(m_out, 0, 32'h8001_A534);
    wr(12'h004, 32'h0000_8001, "R4 high half");
    // R2 R10 bank1 high half truncated at 22 pins
    put_bank(m_out, 1, 32'h003F_0000);
    wr(12'h00C, 32'h0000_FFFF, "R2 R10 bank1 high half");
    // R2 bank3 placement
    put_bank(m_out, 3, 32'h0000_0001);
    wr(12'h018, 32'h0000_0001, "R2 bank3 pin0 at bit 86");
    // R3 all-ones mask is a no-op
    wr(12'h010, 32'hFFFF_FFFF, "R3 all-ones mask");

    // R12 data present but strobe low
    @(negedge clk);
    bus_addr = 12'h000; bus_wdata = 32'h0000_0000; bus_we = 1'b0;
    repeat (3) @(negedge clk);
    pads("R12 no strobe");

    // R9 R7 direction
    wr(12'h204, 32'h0000_0000, "R9 clear pinned dir");
    rd(12'h204, 32'h0000_0180, "R9 pinned dir reads 1");
    m_dir[0] = 32'hFFFF_0181;
    wr(12'h204, 32'hFFFF_0001, "R7 bank0 dir write");
    rd(12'h204, 32'hFFFF_0181, "R7 bank0 dir readback");
    m_dir[1] = 32'h003F_FFFF;
    wr(12'h244, 32'hFFFF_FFFF, "R10 bank1 dir write");
    rd(12'h244, 32'h003F_FFFF, "R10 bank1 dir upper zero");
    m_dir[2] = 32'h0F0F_0F0F;
    wr(12'h284, 32'h0F0F_0F0F, "R7 bank2 dir write");
    rd(12'h284, 32'h0F0F_0F0F, "R7 bank2 dir readback");

    // R8 output enable gated by direction
    m_oen[0] = 32'h0000_00FF;
    wr(12'h208, 32'h0000_00FF, "R8 bank0 oe and dir");
    rd(12'h208, 32'h0000_00FF, "R8 bank0 oen readback");
    m_oen[1] = 32'h003F_FFFF;
    wr(12'h248, 32'hFFFF_FFFF, "R8 R10 bank1 oe");
    rd(12'h248, 32'h003F_FFFF, "R10 bank1 oen upper zero");
    m_oen[3] = 32'hFFFF_FFFF;
    wr(12'h2C8, 32'hFFFF_FFFF, "R8 bank3 oe without dir");

    // R11 write-only and unmapped reads, ignored writes
    rd(12'h000, 32'h0, "R11 masked reg reads zero");
    rd(12'h014, 32'h0, "R11 masked reg reads zero");
    rd(12'h100, 32'h0, "R11 unmapped reads zero");
    wr(12'h060, 32'hFFFF_FFFF, "R11 write to input reg");
    wr(12'h300, 32'hFFFF_FFFF, "R11 write to unmapped");
    rd(12'h204, 32'hFFFF_0181, "R11 dir untouched");
    rd(12'h060, 32'h0, "R11 R6 input reg unchanged");

    // R6 R10 inputs
    @(negedge clk);
    pad_in = '1;
    repeat (3) @(negedge clk);
    rd(12'h064, 32'h003F_FFFF, "R6 R10 bank1 inputs");
    rd(12'h06C, 32'hFFFF_FFFF, "R6 bank3 inputs");
    rd(12'h068, 32'hFFFF_FFFF, "R6 bank2 before change");
    // R6 two-edge synchroniser latency
    @(negedge clk);
    for (int i = 0; i < 32; i++) pad_in[54 + i] = 1'(32'h1357_2468 >> i);
    push(0, NPIN'(32'hFFFF_FFFF), "R6 one edge old level");
    @(negedge clk);
    push(0, NPIN'(32'h1357_2468), "R6 two edges new level");
    rd(12'h060, 32'hFFFF_FFFF, "R6 bank0 inputs");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule